// File: doc/BRIEF.md
# Smart Card Character Transmitter with Error-Signal Retry

This block sends one byte at a time to a smart card over a single half-duplex I/O line that is pulled up and driven low through an open-drain stage. Each character is framed as a start bit, the data bits least significant first, and a parity bit, followed by a guard window in which the line is released. The transmitter pulls the line low for every zero it sends and releases it for every one.

In the character-oriented card protocol the card reports a parity error it has seen by pulling the line low during the guard window. When that protocol is selected and error detection is enabled, the block samples the line inside the guard window. It can then resend the same character automatically, up to a programmable number of times, after a short gap. For test use, a control input makes the block send odd parity on every character, so that the card's error path can be exercised. Bit timing comes from an external elementary-time-unit (etu) tick, and bytes are supplied one at a time with a strobe.

Top module: `sctx_t0_tx`

## Requirements
- R1: After reset `line_pull`, `busy`, `done`, `fail` and `brk_seen` are all 0.
- R2: A frame is one etu of start (`line_pull`=1), then `tx_data[0]` through `tx_data[7]` one etu each (`line_pull` = inverse of the bit), one etu of parity (`line_pull` = inverse of the parity bit), then 2 etu of guard with `line_pull`=0. The start etu begins at the clock edge that accepts `tx_send`, and every later etu boundary is a clock edge with `etu_tick`=1.
- R3: With `inject_odd`=0 the parity bit makes the number of ones across the 8 data bits and the parity bit even.
- R4: With `inject_odd`=1 every frame, including retransmissions, carries the inverse of the even parity bit.
- R5: The line is sampled at the etu boundary that ends the first guard etu, which is 11 etu after the start edge. A low level there is a detected error signal only when `proto_t0`=1 and `brk_det_en`=1. A detection pulses `brk_seen` for one clock.
- R6: After a detected error signal, if `retx_en`=1 and fewer than `retry_max` retransmissions have been made for this byte, the same frame is sent again. Its start bit begins one etu after the guard ends, which is 2 etu after the sample point. `busy` stays high throughout.
- R7: With `brk_det_en`=0 or `proto_t0`=0, a low line in the guard window causes no retransmission, and the character ends with `done`.
- R8: A detected error signal that cannot be retried, because `retx_en`=0 or because `retry_max` retransmissions have already been made, ends the character with a one-clock `fail` pulse. `busy` drops and no further frame is sent.
- R9: `busy` is high from the edge that accepts `tx_send` until the edge that ends the guard of a character with no detected error. At that edge `done` pulses for one clock and `busy` drops.
- R10: `tx_send` while `busy` is high is ignored. The frame in progress and its data are unaffected, and no new frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Byte to send, captured with `tx_send` |
| tx_send | input | 1 | Start strobe, honoured only while idle |
| etu_tick | input | 1 | One-clock pulse marking each etu boundary |
| proto_t0 | input | 1 | 1 selects the character protocol with error signalling |
| brk_det_en | input | 1 | 1 enables sampling of the card's error signal |
| retx_en | input | 1 | 1 enables automatic retransmission |
| inject_odd | input | 1 | Test control: send odd parity |
| retry_max | input | 3 | Maximum retransmissions per byte |
| line_in | input | 1 | Synchronised level of the I/O line |
| line_pull | output | 1 | 1 pulls the I/O line low, 0 releases it |
| busy | output | 1 | Character in progress |
| brk_seen | output | 1 | One-clock pulse on a detected error signal |
| done | output | 1 | One-clock pulse when a character is accepted |
| fail | output | 1 | One-clock pulse when a character is abandoned |

## Verification
The bench plays the card. It pulls the line low exactly in the sample etu and checks the retry count boundary: with a limit of two, a design that compared off by one would send a third retransmission or give up after the first. It pulls the line low with detection off and with the other protocol selected. A design that gated detection on only one of those controls would retransmit there. It checks that retransmitted frames repeat the original bits and the forced odd parity, and that a strobe arriving mid-frame neither corrupts the shifting byte nor queues a second frame.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_HOLD  = 2'd2
  } sctx_state_e;
endpackage

// File: rtl/sctx_parity.sv
// Parity bit for a data word: even by default, inverted when odd is forced.
module sctx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic              force_odd,
  output logic              par
);
  assign par = (^word) ^ force_odd;
endmodule

// File: rtl/sctx_bit_sel.sv
// Line drive for a given etu position of the frame (1 = pull low).
module sctx_bit_sel #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic [IDX_W-1:0]  pos,
  input  logic [DATA_W-1:0] word,
  input  logic              par,
  output logic              pull
);
  always_comb begin
    pull = 1'b0;
    if (pos == '0) begin
      pull = 1'b1;
    end
    for (int i = 0; i < DATA_W; i++) begin
      if (pos == IDX_W'(i + 1)) begin
        pull = ~word[i];
      end
    end
    if (pos == IDX_W'(DATA_W + 1)) begin
      pull = ~par;
    end
  end
endmodule

// File: rtl/sctx_retry_ctl.sv
// Counts retransmissions of the current byte against the programmed limit.
module sctx_retry_ctl #(
  parameter int RETRY_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               bump,
  input  logic [RETRY_W-1:0] limit,
  output logic               allow
);
  logic [RETRY_W-1:0] used;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      used <= '0;
    end else if (bump && used != '1) begin
      used <= used + 1'b1;
    end
  end

  assign allow = (used < limit);
endmodule

// File: rtl/sctx_t0_tx.sv
module sctx_t0_tx
  import sctx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int GUARD_ETU = 2,
  parameter int GAP_ETU   = 1,
  parameter int RETRY_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               tx_send,
  input  logic               etu_tick,
  input  logic               proto_t0,
  input  logic               brk_det_en,
  input  logic               retx_en,
  input  logic               inject_odd,
  input  logic [RETRY_W-1:0] retry_max,
  input  logic               line_in,
  output logic               line_pull,
  output logic               busy,
  output logic               brk_seen,
  output logic               done,
  output logic               fail
);
  localparam int LAST_POS   = DATA_W + 1 + GUARD_ETU;
  localparam int SAMPLE_POS = DATA_W + 2;
  localparam int IDX_W      = $clog2(LAST_POS + 2);

  sctx_state_e       state;
  logic [IDX_W-1:0]  pos;
  logic [DATA_W-1:0] word;
  logic              hit;
  logic              par;
  logic              next_pull;
  logic              allow;
  logic              det_on;
  logic              start_new;
  logic              restart;
  logic [IDX_W-1:0]  pos_next;

  assign det_on    = proto_t0 & brk_det_en;
  assign pos_next  = pos + 1'b1;
  assign start_new = (state == ST_IDLE) && tx_send;
  assign restart   = (state == ST_HOLD) && etu_tick && (pos == IDX_W'(GAP_ETU - 1));

  sctx_parity #(.DATA_W(DATA_W)) u_par (
    .word      (word),
    .force_odd (inject_odd),
    .par       (par)
  );

  sctx_bit_sel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
    .pos  (pos_next),
    .word (word),
    .par  (par),
    .pull (next_pull)
  );

  sctx_retry_ctl #(.RETRY_W(RETRY_W)) u_retry (
    .clk   (clk),
    .rst   (rst),
    .clear (start_new),
    .bump  (restart),
    .limit (retry_max),
    .allow (allow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pos       <= '0;
      word      <= '0;
      hit       <= 1'b0;
      line_pull <= 1'b0;
      busy      <= 1'b0;
      brk_seen  <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      brk_seen <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tx_send) begin
            word      <= tx_data;
            pos       <= '0;
            hit       <= 1'b0;
            line_pull <= 1'b1;
            busy      <= 1'b1;
            state     <= ST_FRAME;
          end
        end
        ST_FRAME: begin
          if (etu_tick) begin
            pos       <= pos_next;
            line_pull <= next_pull;
            if (pos == IDX_W'(SAMPLE_POS)) begin
              hit      <= det_on & ~line_in;
              brk_seen <= det_on & ~line_in;
            end
            if (pos == IDX_W'(LAST_POS)) begin
              pos       <= '0;
              line_pull <= 1'b0;
              if (!hit) begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end else if (retx_en && allow) begin
                state <= ST_HOLD;
              end else begin
                fail  <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_HOLD: begin
          if (etu_tick) begin
            if (restart) begin
              pos       <= '0;
              hit       <= 1'b0;
              line_pull <= 1'b1;
              state     <= ST_FRAME;
            end else begin
              pos <= pos_next;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sctx_t0_tx_chk.sv
module sctx_t0_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_send,
  input logic proto_t0,
  input logic brk_det_en,
  input logic line_pull,
  input logic busy,
  input logic brk_seen,
  input logic done,
  input logic fail
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_pull);

  assert_busy_from_send_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tx_send));

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_detect_gated_R5: assert property (@(posedge clk) disable iff (rst)
    brk_seen |-> ($past(proto_t0 && brk_det_en) && busy));

  assert_fail_ends_busy_R8: assert property (@(posedge clk) disable iff (rst)
    fail |-> (!busy && !done));
endmodule

bind sctx_t0_tx sctx_t0_tx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_send    (tx_send),
  .proto_t0   (proto_t0),
  .brk_det_en (brk_det_en),
  .line_pull  (line_pull),
  .busy       (busy),
  .brk_seen   (brk_seen),
  .done       (done),
  .fail       (fail)
);

// File: tb/sctx_t0_tx_test.sv
`timescale 1ns/1ps
module sctx_t0_tx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_send = 1'b0;
  logic       etu_tick = 1'b0;
  logic       proto_t0 = 1'b1;
  logic       brk_det_en = 1'b1;
  logic       retx_en = 1'b1;
  logic       inject_odd = 1'b0;
  logic [2:0] retry_max = 3'd2;
  logic       card_pull = 1'b0;
  logic       line_in;
  logic       line_pull, busy, brk_seen, done, fail;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign line_in = ~(line_pull | card_pull);

  sctx_t0_tx uut (
    .clk(clk), .rst(rst), .tx_data(tx_data), .tx_send(tx_send),
    .etu_tick(etu_tick), .proto_t0(proto_t0), .brk_det_en(brk_det_en),
    .retx_en(retx_en), .inject_odd(inject_odd), .retry_max(retry_max),
    .line_in(line_in), .line_pull(line_pull), .busy(busy),
    .brk_seen(brk_seen), .done(done), .fail(fail)
  );

  // {expected parity bit, inject_odd, data}
  localparam logic [9:0] VECS [0:6] = '{
    {1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'hFF},
    {1'b0, 1'b0, 8'hA5},
    {1'b1, 1'b0, 8'h01},
    {1'b1, 1'b0, 8'h07},
    {1'b0, 1'b1, 8'h80},
    {1'b1, 1'b1, 8'h3C}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic etu();
    @(negedge clk) etu_tick = 1'b1;
    @(negedge clk) etu_tick = 1'b0;
  endtask

  function automatic logic [9:0] frame_of(input logic [7:0] d, input logic p);
    logic [9:0] f;
    f[0] = 1'b1;
    for (int k = 0; k < 8; k++) f[k+1] = ~d[k];
    f[9] = ~p;
    return f;
  endfunction

  function automatic logic even_par(input logic [7:0] d);
    int n = 0;
    for (int k = 0; k < 8; k++) if (d[k]) n++;
    return logic'(n % 2);
  endfunction

  // One frame: optionally starts with a send strobe, otherwise with the gap etu.
  task automatic run_char(input bit do_send, input logic [7:0] d, input bit pull,
                          input bit poke, output logic [9:0] bits,
                          output bit guard_ok, output bit busy_ok,
                          output logic sawbrk, output logic e_done,
                          output logic e_fail, output logic e_busy);
    guard_ok = 1'b1;
    busy_ok  = 1'b1;
    if (do_send) begin
      @(negedge clk) begin tx_data = d; tx_send = 1'b1; end
      @(negedge clk) tx_send = 1'b0;
    end else begin
      etu();
    end
    bits[0] = line_pull;
    if (!busy) busy_ok = 1'b0;
    for (int k = 1; k <= 12; k++) begin
      if (poke && k == 3) begin
        @(negedge clk) begin tx_data = 8'h55; tx_send = 1'b1; end
        @(negedge clk) tx_send = 1'b0;
      end
      if (k == 11) card_pull = pull;
      etu();
      if (k == 11) card_pull = 1'b0;
      if (k <= 9) bits[k] = line_pull;
      if ((k == 10 || k == 11) && line_pull) guard_ok = 1'b0;
      if (k < 12 && !busy) busy_ok = 1'b0;
      if (k == 11) sawbrk = brk_seen;
      if (k == 12) begin e_done = done; e_fail = fail; e_busy = busy; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [9:0] bits, first;
    bit g, b;
    logic sb, ed, ef, eb;

    repeat (4) @(negedge clk);
    check(line_pull == 0 && busy == 0 && done == 0 && fail == 0 && brk_seen == 0,
          "R1 reset outputs", {line_pull, busy, done, fail, brk_seen}, 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(line_pull == 0 && busy == 0, "R1 after release", {line_pull, busy}, 0);

    // Table walk: clean characters, even and forced-odd parity.
    for (int v = 0; v < 7; v++) begin
      inject_odd = VECS[v][8];
      run_char(1'b1, VECS[v][7:0], 1'b0, 1'b0, bits, g, b, sb, ed, ef, eb);
      check(bits == frame_of(VECS[v][7:0], VECS[v][9]),
            VECS[v][8] ? "R4 odd parity frame" : "R2 R3 frame bits", bits,
            frame_of(VECS[v][7:0], VECS[v][9]));
      check(VECS[v][9] == (even_par(VECS[v][7:0]) ^ VECS[v][8]), "R3 table parity",
            VECS[v][9], even_par(VECS[v][7:0]) ^ VECS[v][8]);
      check(g, "R2 guard released", g, 1);
      check(b && ed && !ef && !eb && !sb, "R9 clean completion",
            {b, ed, ef, eb, sb}, 5'b11000);
    end
    inject_odd = 1'b0;

    // Retries up to the limit of two, then failure.
    retry_max = 3'd2;
    run_char(1'b1, 8'hA5, 1'b1, 1'b0, first, g, b, sb, ed, ef, eb);
    check(sb == 1, "R5 error signal seen", sb, 1);
    check(!ed && !ef && eb, "R6 busy kept for retry", {ed, ef, eb}, 3'b001);
    run_char(1'b0, 8'hA5, 1'b1, 1'b0, bits, g, b, sb, ed, ef, eb);
    check(bits == first, "R6 first retransmission repeats frame", bits, first);
    check(sb && !ed && !ef && eb && b, "R6 second retry pending",
          {sb, ed, ef, eb, b}, 5'b10011);
    run_char(1'b0, 8'hA5, 1'b1, 1'b0, bits, g, b, sb, ed, ef, eb);
    check(bits == first, "R6 second retransmission repeats frame", bits, first);
    check(ef && !ed && !eb, "R8 fail at retry limit", {ef, ed, eb}, 3'b100);
    etu(); etu();
    check(!line_pull && !busy, "R8 no frame after fail", {line_pull, busy}, 0);

    // Retry followed by a clean retransmission, forced odd parity kept.
    inject_odd = 1'b1;
    run_char(1'b1, 8'h96, 1'b1, 1'b0, first, g, b, sb, ed, ef, eb);
    run_char(1'b0, 8'h96, 1'b0, 1'b0, bits, g, b, sb, ed, ef, eb);
    check(bits == frame_of(8'h96, ~even_par(8'h96)), "R4 retransmitted odd parity",
          bits, frame_of(8'h96, ~even_par(8'h96)));
    check(ed && !ef && !eb, "R6 retry then accepted", {ed, ef, eb}, 3'b100);
    inject_odd = 1'b0;

    // Detection disabled.
    brk_det_en = 1'b0;
    run_char(1'b1, 8'h11, 1'b1, 1'b0, bits, g, b, sb, ed, ef, eb);
    check(!sb && ed && !eb, "R7 detection off ends done", {sb, ed, eb}, 3'b010);
    etu();
    check(!line_pull && !busy, "R7 no retransmit with detection off", {line_pull, busy}, 0);
    brk_det_en = 1'b1;

    // Other protocol selected.
    proto_t0 = 1'b0;
    run_char(1'b1, 8'h22, 1'b1, 1'b0, bits, g, b, sb, ed, ef, eb);
    check(!sb && ed && !eb, "R7 block protocol ignores low line", {sb, ed, eb}, 3'b010);
    etu();
    check(!line_pull && !busy, "R7 no retransmit in block protocol", {line_pull, busy}, 0);
    proto_t0 = 1'b1;

    // Retransmission disabled.
    retx_en = 1'b0;
    run_char(1'b1, 8'h33, 1'b1, 1'b0, bits, g, b, sb, ed, ef, eb);
    check(sb && ef && !ed && !eb, "R8 fail without retransmit", {sb, ef, ed, eb}, 4'b1100);
    retx_en = 1'b1;

    // Zero retry budget.
    retry_max = 3'd0;
    run_char(1'b1, 8'h44, 1'b1, 1'b0, bits, g, b, sb, ed, ef, eb);
    check(ef && !eb, "R8 fail with zero limit", {ef, eb}, 2'b10);
    retry_max = 3'd2;

    // Send strobe during a frame.
    run_char(1'b1, 8'h3C, 1'b0, 1'b1, bits, g, b, sb, ed, ef, eb);
    check(bits == frame_of(8'h3C, even_par(8'h3C)), "R10 frame unaffected by strobe",
          bits, frame_of(8'h3C, even_par(8'h3C)));
    check(ed && !eb, "R10 completes normally", {ed, eb}, 2'b10);
    etu(); etu();
    check(!busy && !line_pull, "R10 strobe not queued", {busy, line_pull}, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule